// File: doc/BRIEF.md
# Multi-lane serial flash transaction sequencer

This block carries out one indirect transaction towards a serial flash device, using settings the host has already placed on its configuration inputs. After a start request it selects one of several targets, produces the serial clock and drives or samples up to eight data lanes. It moves through a one-byte opcode phase, an optional address phase of up to four bytes, an optional dummy phase counted in serial clock cycles and an optional data phase. The opcode, address and data phases each have their own lane count and bit order.

Data bytes pass one at a time through a host-side port. The write-ready flag asks for the next byte to send. The read-ready flag offers a byte that has been captured. Whenever the host has not yet serviced the port, the serial clock stops at the byte boundary, so no byte is ever lost. The length of the data phase is either a programmed byte count or open-ended. An open-ended phase ends at the next byte boundary after a stop request. Completion is flagged right after chip select is released.

The serial clock runs at half the system clock. Its low half lasts one system cycle and its high half lasts one system cycle. Outgoing lanes change only at the start of a low half.

Top module: `sflash_seq`

## Requirements
- R1: After reset, every `cs_n` line is high, `sck` is low, `io_oe` is zero and `wr_ready`, `rd_ready` and `xfer_done` are low.
- R2: A 1 on `start_req` in the idle state starts a transaction. It drives low exactly the one `cs_n` line whose index is `cs_sel`, and that line stays low for the whole transaction. A start request during a transaction has no effect, and neither does a change of `cs_sel` during a transaction.
- R3: A lane-mode code of 0, 1, 2 or 3 selects 1, 2, 4 or 8 lanes. These are lanes `io[w-1:0]`, and a byte then takes 8/w serial cycles. During opcode, address and write-data beats `io_oe` equals the mask of those lanes.
- R4: With a phase's bit-order flag at 0, each byte goes out most significant group first, and lane w-1 carries the most significant bit of a group. With the flag at 1, the least significant group goes first and lane 0 carries the lowest bit. Address bytes always go out most significant byte first.
- R5: The opcode phase is one byte. The address phase is `addr_len` bytes, from 0 to 4, and 0 skips it. The dummy phase is `dummy_cycles` serial cycles, from 0 to 255, with `io_oe` zero.
- R6: With `data_en` low, the transaction ends after the dummy phase. With `data_en` high, `data_write`=1 sends host bytes and `data_write`=0 captures bytes from `io_in` with `io_oe` zero.
- R7: With `size_valid` high, the data phase is exactly `size_m1`+1 bytes, up to 2048.
- R8: With `size_valid` low, the data phase continues byte after byte. After a `stop_req` pulse it ends at the next byte boundary.
- R9: `wr_ready` is high while a write transaction has no byte buffered. A `wr_strobe` clears it, and the serial clock pauses at a byte boundary while no byte is buffered.
- R10: `rd_ready` rises when a full byte has been captured into `rd_data`. A `rd_strobe` clears it, and the serial clock pauses at the next byte boundary until it is cleared.
- R11: With `sample_late` at 0, input lanes are captured on the rising `sck` edge. With it at 1, they are captured on the falling edge.
- R12: `xfer_done` rises one clock after all `cs_n` lines return high, with `sck` low, and a new start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Write-one start action |
| stop_req | input | 1 | Write-one stop action for open-ended data |
| cs_sel | input | 2 | Index of the target to select |
| op_code | input | 8 | Opcode byte |
| op_mode | input | 2 | Opcode lane-mode code |
| op_lsb | input | 1 | Opcode bit order, 1 = least significant first |
| addr_val | input | 32 | Address value |
| addr_len | input | 3 | Address bytes, 0 to 4 |
| addr_mode | input | 2 | Address lane-mode code |
| addr_lsb | input | 1 | Address bit order |
| dummy_cycles | input | 8 | Dummy serial cycles |
| data_en | input | 1 | Data phase enable |
| data_write | input | 1 | Data direction, 1 = write |
| data_mode | input | 2 | Data lane-mode code |
| data_lsb | input | 1 | Data bit order |
| size_valid | input | 1 | Byte count is valid |
| size_m1 | input | 11 | Byte count minus one |
| sample_late | input | 1 | Capture edge, 1 = falling |
| wr_strobe | input | 1 | Host writes a data byte |
| wr_data | input | 8 | Byte written by the host |
| wr_ready | output | 1 | Block accepts the next byte |
| rd_strobe | input | 1 | Host reads the data byte |
| rd_data | output | 8 | Last captured byte |
| rd_ready | output | 1 | A captured byte is waiting |
| xfer_done | output | 1 | Transaction complete |
| sck | output | 1 | Serial clock |
| cs_n | output | 4 | Active-low chip selects |
| io_out | output | 8 | Lane output values |
| io_oe | output | 8 | Lane output enables |
| io_in | input | 8 | Lane input values |

## Verification
Outgoing lane values are due once `sck` has risen for a beat, so the bench records them on every rising edge of `sck` and compares the whole list with a stream built from the requirements. The input lanes are driven as a flash device would drive them. In mode 0 the bench presents a beat on the falling edge before it, and in mode 1 on that beat's own rising edge, so only the correct capture edge gives the expected bytes. Host flags are due one system clock after the edge that sets or clears them. Inputs are driven and outputs sampled on the falling system clock edge. `xfer_done` is sampled from the cycle after chip select releases. To check that the clock stops at a byte boundary, the bench holds back its service of the port for many cycles and compares the count of rising edges taken before and after.

// File: rtl/sfq_pkg.sv
package sfq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA, PH_FIN
  } phase_e;

  // lanes used by a mode code: 1, 2, 4, 8
  function automatic logic [3:0] lane_cnt(input logic [1:0] m);
    return 4'd1 << m;
  endfunction

  // index of the final beat in a byte
  function automatic logic [2:0] last_beat(input logic [1:0] m);
    return 3'((4'd8 >> m) - 4'd1);
  endfunction

  function automatic logic [7:0] lane_mask(input logic [1:0] m);
    return 8'((9'd1 << lane_cnt(m)) - 9'd1);
  endfunction

  // first byte bit carried by a beat
  function automatic int beat_base(input logic [1:0] m, input logic lsb,
                                   input logic [2:0] idx);
    int w;
    w = int'(lane_cnt(m));
    return lsb ? int'(idx) * w : 8 - (int'(idx) + 1) * w;
  endfunction

  function automatic logic [7:0] lane_pick(input logic [7:0] b, input logic [1:0] m,
                                           input logic lsb, input logic [2:0] idx);
    logic [7:0] r;
    int base;
    r = '0;
    base = beat_base(m, lsb, idx);
    for (int l = 0; l < 8; l++)
      if (l < int'(lane_cnt(m))) r[3'(l)] = b[3'(base + l)];
    return r;
  endfunction

  function automatic logic [7:0] lane_merge(input logic [7:0] cur, input logic [7:0] lanes,
                                            input logic [1:0] m, input logic lsb,
                                            input logic [2:0] idx);
    logic [7:0] r;
    int base;
    r = cur;
    base = beat_base(m, lsb, idx);
    for (int l = 0; l < 8; l++)
      if (l < int'(lane_cnt(m))) r[3'(base + l)] = lanes[3'(l)];
    return r;
  endfunction

  // address byte u of n, most significant byte first
  function automatic logic [7:0] addr_pick(input logic [31:0] a, input logic [2:0] n,
                                           input logic [1:0] u);
    logic [1:0] k;
    k = 2'(n - 3'd1 - {1'b0, u});
    return 8'(a >> {k, 3'b000});
  endfunction

endpackage

// File: rtl/sfq_fsm.sv
module sfq_fsm
  import sfq_pkg::*;
#(
  parameter int CS_W  = 2,
  parameter int CNT_W = 11,
  parameter int DMY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic [CS_W-1:0]  cs_sel,
  input  logic [1:0]       op_mode,
  input  logic [2:0]       addr_len,
  input  logic [1:0]       addr_mode,
  input  logic [DMY_W-1:0] dummy_cycles,
  input  logic             data_en,
  input  logic [1:0]       data_mode,
  input  logic             size_valid,
  input  logic [CNT_W-1:0] size_m1,
  input  logic             data_hold,
  output phase_e           phase,
  output logic             sck,
  output logic [2:0]       idx,
  output logic [CNT_W-1:0] unit,
  output logic [CS_W-1:0]  cs_idx,
  output logic             active,
  output logic             done,
  output logic             rise_ev,
  output logic             fall_ev,
  output logic             byte_done_ev,
  output logic             start_ev
);

  phase_e           ph_q, after_dmy, after_addr;
  logic             sck_q, stop_q, done_q;
  logic [2:0]       idx_q;
  logic [CNT_W-1:0] unit_q;
  logic [DMY_W-1:0] dmy_q;
  logic [CS_W-1:0]  cs_q;
  logic [1:0]       cur_mode;
  logic             at_bound, open_stop, beat_last;

  always_comb begin
    case (ph_q)
      PH_CMD:  cur_mode = op_mode;
      PH_ADDR: cur_mode = addr_mode;
      PH_DATA: cur_mode = data_mode;
      default: cur_mode = 2'd0;
    endcase
  end

  assign active       = (ph_q == PH_CMD) || (ph_q == PH_ADDR) ||
                        (ph_q == PH_DUMMY) || (ph_q == PH_DATA);
  assign at_bound     = (ph_q == PH_DATA) && (idx_q == 3'd0) && !sck_q;
  assign open_stop    = at_bound && !size_valid && stop_q;
  assign rise_ev      = active && !sck_q && !open_stop && !(at_bound && data_hold);
  assign fall_ev      = active && sck_q;
  assign beat_last    = (idx_q == last_beat(cur_mode));
  assign byte_done_ev = fall_ev && (ph_q == PH_DATA) && beat_last;
  assign start_ev     = (ph_q == PH_IDLE) && start_req;
  assign after_dmy    = data_en ? PH_DATA : PH_FIN;
  assign after_addr   = (dummy_cycles != '0) ? PH_DUMMY : after_dmy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      sck_q  <= 1'b0;
      idx_q  <= '0;
      unit_q <= '0;
      dmy_q  <= '0;
      stop_q <= 1'b0;
      done_q <= 1'b0;
      cs_q   <= '0;
    end else begin
      if (stop_req && ph_q != PH_IDLE) stop_q <= 1'b1;
      case (ph_q)
        PH_IDLE: if (start_req) begin
          ph_q   <= PH_CMD;
          idx_q  <= '0;
          unit_q <= '0;
          dmy_q  <= '0;
          stop_q <= 1'b0;
          done_q <= 1'b0;
          cs_q   <= cs_sel;
        end
        PH_FIN: begin
          ph_q   <= PH_IDLE;
          done_q <= 1'b1;
        end
        default: begin
          if (open_stop) begin
            ph_q <= PH_FIN;
          end else if (rise_ev) begin
            sck_q <= 1'b1;
          end else if (fall_ev) begin
            sck_q <= 1'b0;
            if (ph_q == PH_DUMMY) begin
              if (dmy_q == dummy_cycles - DMY_W'(1)) begin
                ph_q  <= after_dmy;
                dmy_q <= '0;
              end else begin
                dmy_q <= dmy_q + DMY_W'(1);
              end
            end else if (beat_last) begin
              idx_q <= '0;
              case (ph_q)
                PH_CMD: begin
                  ph_q   <= (addr_len != 3'd0) ? PH_ADDR : after_addr;
                  unit_q <= '0;
                end
                PH_ADDR:
                  if (unit_q == CNT_W'(addr_len) - CNT_W'(1)) begin
                    ph_q   <= after_addr;
                    unit_q <= '0;
                  end else begin
                    unit_q <= unit_q + CNT_W'(1);
                  end
                default:
                  if (size_valid && unit_q == size_m1) ph_q <= PH_FIN;
                  else unit_q <= unit_q + CNT_W'(1);
              endcase
            end else begin
              idx_q <= idx_q + 3'd1;
            end
          end
        end
      endcase
    end
  end

  assign phase  = ph_q;
  assign sck    = sck_q;
  assign idx    = idx_q;
  assign unit   = unit_q;
  assign cs_idx = cs_q;
  assign done   = done_q;

  // R12: completion follows the release of chip select by one clock
  a_r12_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |=> done);

  // R8: an open-ended data phase never ends without a stop request
  a_r8_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DATA && !size_valid && !stop_q && !stop_req) |=> ph_q != PH_FIN);

endmodule

// File: rtl/sfq_datapath.sv
module sfq_datapath
  import sfq_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase,
  input  logic             sck,
  input  logic [2:0]       idx,
  input  logic [CNT_W-1:0] unit,
  input  logic             rise_ev,
  input  logic             fall_ev,
  input  logic             byte_done_ev,
  input  logic             start_ev,
  input  logic [7:0]       op_code,
  input  logic [1:0]       op_mode,
  input  logic             op_lsb,
  input  logic [31:0]      addr_val,
  input  logic [2:0]       addr_len,
  input  logic [1:0]       addr_mode,
  input  logic             addr_lsb,
  input  logic             data_en,
  input  logic             data_write,
  input  logic [1:0]       data_mode,
  input  logic             data_lsb,
  input  logic             sample_late,
  input  logic             wr_strobe,
  input  logic [7:0]       wr_data,
  input  logic             rd_strobe,
  input  logic [7:0]       io_in,
  output logic [7:0]       io_out,
  output logic [7:0]       io_oe,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_ready,
  output logic             data_hold
);

  logic [7:0] wbuf_q, rx_q, rd_q, rx_next, cur_byte;
  logic       wfull_q, rrdy_q, busy, capture_ev;
  logic [1:0] cur_mode;
  logic       cur_lsb;

  always_comb begin
    cur_byte = 8'h00;
    cur_mode = 2'd0;
    cur_lsb  = 1'b0;
    io_oe    = 8'h00;
    case (phase)
      PH_CMD: begin
        cur_byte = op_code; cur_mode = op_mode; cur_lsb = op_lsb;
        io_oe    = lane_mask(op_mode);
      end
      PH_ADDR: begin
        cur_byte = addr_pick(addr_val, addr_len, unit[1:0]);
        cur_mode = addr_mode; cur_lsb = addr_lsb;
        io_oe    = lane_mask(addr_mode);
      end
      PH_DATA: begin
        cur_byte = wbuf_q; cur_mode = data_mode; cur_lsb = data_lsb;
        io_oe    = data_write ? lane_mask(data_mode) : 8'h00;
      end
      default: ;
    endcase
  end

  assign io_out     = (io_oe != 8'h00) ? lane_pick(cur_byte, cur_mode, cur_lsb, idx) : 8'h00;
  assign rx_next    = lane_merge(rx_q, io_in, data_mode, data_lsb, idx);
  assign capture_ev = (phase == PH_DATA) && !data_write && (sample_late ? fall_ev : rise_ev);
  assign busy       = (phase != PH_IDLE) && (phase != PH_FIN);
  assign wr_ready   = busy && data_en && data_write && !wfull_q;
  assign data_hold  = data_write ? !wfull_q : rrdy_q;
  assign rd_data    = rd_q;
  assign rd_ready   = rrdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbuf_q  <= '0;
      wfull_q <= 1'b0;
      rx_q    <= '0;
      rd_q    <= '0;
      rrdy_q  <= 1'b0;
    end else if (start_ev) begin
      wfull_q <= 1'b0;
      rrdy_q  <= 1'b0;
    end else begin
      if (wr_strobe && wr_ready) begin
        wbuf_q  <= wr_data;
        wfull_q <= 1'b1;
      end
      if (rd_strobe) rrdy_q <= 1'b0;
      if (capture_ev) rx_q <= rx_next;
      if (byte_done_ev) begin
        if (data_write) begin
          wfull_q <= 1'b0;
        end else begin
          rrdy_q <= 1'b1;
          rd_q   <= sample_late ? rx_next : rx_q;
        end
      end
    end
  end

  // R9: no write beat starts while the buffer is empty
  a_r9_write_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && data_write && !wfull_q) |-> !rise_ev);

  // R10: no new read byte starts while the previous one is unread
  a_r10_read_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && !data_write && rrdy_q && idx == 3'd0 && !sck) |-> !rise_ev);

  a_r9_wr_ready_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && wr_ready) |=> !wr_ready);

  a_r10_rd_ready_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && rd_ready) |=> !rd_ready);

endmodule

// File: rtl/sflash_seq.sv
module sflash_seq
  import sfq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CNT_W  = 11,
  parameter int DMY_W  = 8,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic [CS_W-1:0]  cs_sel,
  input  logic [7:0]       op_code,
  input  logic [1:0]       op_mode,
  input  logic             op_lsb,
  input  logic [31:0]      addr_val,
  input  logic [2:0]       addr_len,
  input  logic [1:0]       addr_mode,
  input  logic             addr_lsb,
  input  logic [DMY_W-1:0] dummy_cycles,
  input  logic             data_en,
  input  logic             data_write,
  input  logic [1:0]       data_mode,
  input  logic             data_lsb,
  input  logic             size_valid,
  input  logic [CNT_W-1:0] size_m1,
  input  logic             sample_late,
  input  logic             wr_strobe,
  input  logic [7:0]       wr_data,
  output logic             wr_ready,
  input  logic             rd_strobe,
  output logic [7:0]       rd_data,
  output logic             rd_ready,
  output logic             xfer_done,
  output logic             sck,
  output logic [NUM_CS-1:0] cs_n,
  output logic [7:0]       io_out,
  output logic [7:0]       io_oe,
  input  logic [7:0]       io_in
);

  phase_e           phase;
  logic [2:0]       idx;
  logic [CNT_W-1:0] unit;
  logic [CS_W-1:0]  cs_idx;
  logic             active, rise_ev, fall_ev, byte_done_ev, start_ev, data_hold;

  sfq_fsm #(.CS_W(CS_W), .CNT_W(CNT_W), .DMY_W(DMY_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .cs_sel(cs_sel), .op_mode(op_mode), .addr_len(addr_len), .addr_mode(addr_mode),
    .dummy_cycles(dummy_cycles), .data_en(data_en), .data_mode(data_mode),
    .size_valid(size_valid), .size_m1(size_m1), .data_hold(data_hold),
    .phase(phase), .sck(sck), .idx(idx), .unit(unit), .cs_idx(cs_idx),
    .active(active), .done(xfer_done), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .byte_done_ev(byte_done_ev), .start_ev(start_ev)
  );

  sfq_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .phase(phase), .sck(sck), .idx(idx), .unit(unit),
    .rise_ev(rise_ev), .fall_ev(fall_ev), .byte_done_ev(byte_done_ev),
    .start_ev(start_ev), .op_code(op_code), .op_mode(op_mode), .op_lsb(op_lsb),
    .addr_val(addr_val), .addr_len(addr_len), .addr_mode(addr_mode),
    .addr_lsb(addr_lsb), .data_en(data_en), .data_write(data_write),
    .data_mode(data_mode), .data_lsb(data_lsb), .sample_late(sample_late),
    .wr_strobe(wr_strobe), .wr_data(wr_data), .rd_strobe(rd_strobe),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_ready(rd_ready), .data_hold(data_hold)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = !(active && cs_idx == CS_W'(g));
  end

  // R2: at most one target selected, and the clock moves only inside a selection
  a_r2_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  a_r2_sck_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !(&cs_n));

  // R2: the selected target holds for the whole transaction
  a_r2_cs_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&cs_n) && !$isunknown($past(cs_n)) && !(&$past(cs_n))) |-> $stable(cs_n));

endmodule

// File: tb/sflash_seq_bench.sv
`timescale 1ns/1ps
module sflash_seq_bench;

  localparam int MAXB = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_req = 0, stop_req = 0, op_lsb = 0, addr_lsb = 0, data_en = 0;
  logic data_write = 0, data_lsb = 0, size_valid = 0, sample_late = 0;
  logic wr_strobe = 0, rd_strobe = 0;
  logic [1:0] cs_sel = 0, op_mode = 0, addr_mode = 0, data_mode = 0;
  logic [7:0] op_code = 0, dummy_cycles = 0, wr_data = 0, io_in = 0;
  logic [31:0] addr_val = 0;
  logic [2:0] addr_len = 0;
  logic [10:0] size_m1 = 0;
  logic wr_ready, rd_ready, xfer_done, sck;
  logic [7:0] rd_data, io_out, io_oe;
  logic [3:0] cs_n;

  int checks = 0, errors = 0;
  int nrise = 0, dbeg = 0, nexp = 0;
  int exp_val[MAXB], exp_msk[MAXB], mon_out[MAXB], mon_oe[MAXB], mon_cs[MAXB];
  int wdat[2048], got[2048];

  always #4 clk = ~clk;

  sflash_seq u_sflash_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .cs_sel(cs_sel), .op_code(op_code), .op_mode(op_mode), .op_lsb(op_lsb),
    .addr_val(addr_val), .addr_len(addr_len), .addr_mode(addr_mode),
    .addr_lsb(addr_lsb), .dummy_cycles(dummy_cycles), .data_en(data_en),
    .data_write(data_write), .data_mode(data_mode), .data_lsb(data_lsb),
    .size_valid(size_valid), .size_m1(size_m1), .sample_late(sample_late),
    .wr_strobe(wr_strobe), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .rd_ready(rd_ready),
    .xfer_done(xfer_done), .sck(sck), .cs_n(cs_n), .io_out(io_out),
    .io_oe(io_oe), .io_in(io_in)
  );

  function automatic logic [7:0] pat(input int j);
    return 8'(j * 53 + 17);
  endfunction

  // flash-side model: record outgoing beats, present incoming beats
  always @(posedge sck or negedge sck) begin
    if (sck) begin
      if (nrise < MAXB) begin
        mon_out[nrise] = int'(io_out);
        mon_oe[nrise]  = int'(io_oe);
        mon_cs[nrise]  = int'(cs_n);
      end
      nrise = nrise + 1;
      if (sample_late) io_in = pat(nrise - 1 - dbeg);
    end else if (!sample_late) begin
      io_in = pat(nrise - dbeg);
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // serialise one byte as the flash should see it
  task automatic push_byte(input int b, input int m, input int lsb, input bit drive);
    int w, msk;
    w   = 1 << m;
    msk = (1 << w) - 1;
    for (int k = 0; k < 8 / w; k++) begin
      exp_val[nexp] = lsb ? ((b >> (k * w)) & msk) : ((((b << (k * w)) & 255) >> (8 - w)) & msk);
      exp_msk[nexp] = drive ? msk : 0;
      nexp++;
    end
  endtask

  function automatic int exp_rx(input int b, input int m, input int lsb);
    int w, v, g, n;
    w = 1 << m;
    n = 8 / w;
    v = 0;
    for (int k = 0; k < n; k++) begin
      g = int'(pat(b * n + k)) & ((1 << w) - 1);
      if (lsb) v = v | (g << (k * w));
      else     v = ((v << w) | g) & 255;
    end
    return v;
  endfunction

  task automatic run(input int om, input int ol, input int al, input int am, input int alsb,
                     input int dc, input int de, input int dw, input int dm, input int dl,
                     input int sv, input int nb, input int late, input int cs,
                     input int dly, input bit restart);
    int mism, n0;
    op_code = 8'($urandom); addr_val = $urandom;
    op_mode = 2'(om); op_lsb = ol[0]; addr_len = 3'(al); addr_mode = 2'(am);
    addr_lsb = alsb[0]; dummy_cycles = 8'(dc); data_en = de[0]; data_write = dw[0];
    data_mode = 2'(dm); data_lsb = dl[0]; size_valid = sv[0]; size_m1 = 11'(nb - 1);
    sample_late = late[0]; cs_sel = 2'(cs);
    for (int i = 0; i < nb; i++) wdat[i] = int'($urandom) & 255;
    nexp = 0;
    push_byte(int'(op_code), om, ol, 1);
    for (int i = 0; i < al; i++) push_byte(int'(addr_val >> (8 * (al - 1 - i))) & 255, am, alsb, 1);
    for (int i = 0; i < dc; i++) begin exp_val[nexp] = 0; exp_msk[nexp] = 0; nexp++; end
    dbeg = nexp;
    if (de != 0) for (int i = 0; i < nb; i++) push_byte(dw != 0 ? wdat[i] : 0, dm, dl, dw != 0);
    nrise = 0;
    @(negedge clk); start_req = 1;
    @(negedge clk); start_req = 0;
    chk(!xfer_done, "R12 done cleared by start", xfer_done, 0);
    if (restart) begin
      repeat (3) @(negedge clk);
      cs_sel = 2'(cs ^ 1); start_req = 1;
      @(negedge clk); start_req = 0; cs_sel = 2'(cs);
    end
    if (de != 0 && dw != 0) begin
      for (int i = 0; i < nb; i++) begin
        while (!wr_ready) @(negedge clk);
        if (i == 1 && dly > 0) begin
          n0 = nrise;
          repeat (dly) @(negedge clk);
          chk(nrise == n0, "R9 clock paused without write byte", nrise, n0);
        end
        wr_strobe = 1; wr_data = 8'(wdat[i]);
        @(negedge clk); wr_strobe = 0;
      end
      if (sv == 0) begin
        while (!wr_ready) @(negedge clk);
        stop_req = 1; @(negedge clk); stop_req = 0;
      end
    end else if (de != 0) begin
      for (int i = 0; i < nb; i++) begin
        while (!rd_ready) @(negedge clk);
        if (sv == 0 && i == nb - 1) begin
          stop_req = 1; @(negedge clk); stop_req = 0;
        end
        if (i == 0 && dly > 0) begin
          n0 = nrise;
          repeat (dly) @(negedge clk);
          chk(nrise == n0, "R10 clock paused with unread byte", nrise, n0);
        end
        got[i] = int'(rd_data);
        rd_strobe = 1; @(negedge clk); rd_strobe = 0;
      end
    end
    while (!xfer_done) @(negedge clk);
    chk(cs_n == 4'hF && !sck, "R12 released at completion", cs_n, 15);
    chk(nrise == nexp, "R5 R7 R8 serial cycle count", nrise, nexp);
    mism = 0;
    for (int i = 0; i < nexp && i < nrise; i++)
      if (mon_oe[i] != exp_msk[i] || (mon_out[i] & exp_msk[i]) != exp_val[i] ||
          mon_cs[i] != (~(1 << cs) & 15)) mism++;
    chk(mism == 0, "R2 R3 R4 R6 beat stream mismatches", mism, 0);
    if (de != 0 && dw == 0) begin
      mism = 0;
      for (int i = 0; i < nb; i++) if (got[i] != exp_rx(i, dm, dl)) mism++;
      chk(mism == 0, "R10 R11 read bytes mismatching", mism, 0);
    end
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(cs_n == 4'hF && !sck && io_oe == 0, "R1 reset lines", {cs_n, io_oe}, 32'hF00);
    chk(!wr_ready && !rd_ready && !xfer_done, "R1 reset flags",
        {wr_ready, rd_ready, xfer_done}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // om ol al am alsb dc de dw dm dl sv nb late cs dly restart
    run(0, 0, 3, 0, 0, 8,   1, 0, 0, 0, 1, 4,    0, 1, 25, 0);
    run(2, 1, 2, 2, 1, 0,   1, 1, 2, 1, 1, 5,    0, 2, 20, 0);
    run(0, 0, 0, 0, 0, 0,   0, 1, 0, 0, 1, 1,    0, 3, 0,  0);
    run(3, 0, 4, 3, 0, 2,   1, 1, 3, 0, 0, 3,    0, 0, 0,  0);
    run(1, 0, 1, 1, 0, 4,   1, 0, 1, 0, 0, 3,    1, 1, 0,  0);
    run(0, 1, 0, 0, 0, 255, 1, 0, 0, 1, 1, 1,    1, 2, 0,  0);
    run(1, 1, 2, 0, 0, 1,   1, 1, 1, 0, 1, 3,    0, 0, 0,  1);
    run(3, 0, 4, 3, 0, 0,   1, 1, 3, 0, 1, 2048, 0, 3, 0,  0);
    run(2, 0, 3, 2, 0, 6,   1, 0, 2, 1, 1, 4,    1, 0, 0,  0);
    for (int t = 0; t < 12; t++)
      run(int'($urandom % 4), int'($urandom % 2), int'($urandom % 5), int'($urandom % 4),
          int'($urandom % 2), ($urandom % 3 == 0) ? int'($urandom % 20) : 0,
          int'($urandom % 4 != 0), int'($urandom % 2), int'($urandom % 4),
          int'($urandom % 2), int'($urandom % 4 != 0), 1 + int'($urandom % 6),
          int'($urandom % 2), int'($urandom % 4), 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule